// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a slave-only two-wire serial port (I2C-compatible timing) that owns a small bank of ten 8-bit control registers. A fast system clock oversamples the serial clock and data lines. Each line passes through a synchronizer and a sample-consensus filter before the block looks for bus conditions. A START condition arms address decoding. The block answers only its own 7-bit device address. It then takes a register pointer and at most one data byte, and a STOP condition closes the transfer.

The register contents leave the block in parallel on `bank_o` for the analog control logic around it. Two 10-bit codes, one for modulation and one for bias, are each split across a low register and a high register. Each code is also given on a port of its own, and that port changes in a single step. The block only ever pulls the data line low, for an acknowledge or a zero read bit. The pad and the pull-up resistor sit outside the block.

Top module: `twi_ctrl_regbank`

## Requirements
- R1: After reset, every bank byte, `mod_code_o` and `bias_code_o` are zero, and `sda_drive_low` is 0.
- R2: The block acknowledges an address byte whose upper seven bits equal DEV_ADDR (default 7'h08) and whose bit 0 gives the direction (0 = write, 1 = read). Any other address gets no acknowledge, and nothing in the bank changes for the rest of that transfer.
- R3: A write transfer (START, address with write, pointer byte, data byte, STOP) acknowledges each byte and stores the data in register `pointer`. Register i appears on `bank_o[8*i+7 : 8*i]`, and no bank byte changes without such a write.
- R4: A read transfer (START, address with read) sends the register chosen by the most recent pointer byte, most significant bit first. Reserved bits read as 0.
- R5: Only the first data byte of a transfer is stored. A later data byte gets no acknowledge and is discarded.
- R6: A pointer above 9 is acknowledged, and so is the data byte that follows, but no register changes. A read from such a pointer returns 0x00.
- R7: Only these bits are writable: all of registers 0, 3, 5, 6 and 7; bits 3:0 of registers 1 and 8; bits 1:0 of registers 2 and 4; and bit 0 of register 9. Every other bit stays 0.
- R8: `mod_code_o` is {register 3, register 2 bits 1:0} and `bias_code_o` is {register 5, register 4 bits 1:0}. Each code changes only when its high register is written. At that moment it takes the low bits that are then stored, so a write to a low register alone leaves the code unchanged.
- R9: A repeated START, with no STOP before it, abandons the current transfer. Address decoding begins again, and nothing from the abandoned transfer is stored.
- R10: `sda_drive_low` changes only while the filtered serial clock is low. It is 0 in the cycle after a STOP.
- R11: A pulse on the serial clock that is shorter than FILT_LEN system-clock samples is not taken as a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_drive_low | output | 1 | 1 = pull the data line low (open-drain enable) |
| bank_o | output | 80 | All ten registers, register i at bits 8*i+7:8*i |
| mod_code_o | output | 10 | Modulation code, updated in one step |
| bias_code_o | output | 10 | Bias code, updated in one step |

## Verification
The bench builds the block with its default parameters: DEV_ADDR 7'h08, two synchronizer stages and a three-sample filter. A quarter bit period of 10 system clocks places the block's roughly seven-cycle input latency well inside each bus phase. With these settings a one-cycle clock glitch falls below the filter threshold. The same values also bring into reach the foreign address, the pointer past the map, the second data byte, the split-code staging and the repeated START, all from random and directed transfers.

// File: rtl/twi_regbank_pkg.sv
`timescale 1ns/1ps
package twi_regbank_pkg;
   localparam int unsigned REG_COUNT   = 10;
   localparam int unsigned CODE_W      = 10;
   localparam int unsigned LO_W        = CODE_W - 8;
   localparam int unsigned MOD_LO_IDX  = 2;
   localparam int unsigned MOD_HI_IDX  = 3;
   localparam int unsigned BIAS_LO_IDX = 4;
   localparam int unsigned BIAS_HI_IDX = 5;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
      ST_DATA, ST_DATA_ACK, ST_TX, ST_TX_ACK, ST_DRAIN
   } slv_state_t;

   // writable bits of each register; unlisted indices are absent
   function automatic logic [7:0] live_mask(input int unsigned idx);
      case (idx)
         0, 3, 5, 6, 7: live_mask = 8'hFF;
         1, 8:          live_mask = 8'h0F;
         2, 4:          live_mask = 8'h03;
         9:             live_mask = 8'h01;
         default:       live_mask = 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/twi_line_filter.sv
`timescale 1ns/1ps
module twi_line_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   generate
      if (FILT_LEN > 1) begin : g_consensus
         logic [FILT_LEN-1:0] hist_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist_q <= '1;
               line_o <= 1'b1;
            end else begin
               hist_q <= {hist_q[FILT_LEN-2:0], synced};
               if (&hist_q)       line_o <= 1'b1;
               else if (~|hist_q) line_o <= 1'b0;
            end
         end
      end else begin : g_bypass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_o <= 1'b1;
            else        line_o <= synced;
         end
      end
   endgenerate
endmodule

// File: rtl/twi_bus_events.sv
`timescale 1ns/1ps
module twi_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign scl_rise  = scl_f & ~scl_q;
   assign scl_fall  = ~scl_f & scl_q;
   assign start_det = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/twi_slave_fsm.sv
`timescale 1ns/1ps
module twi_slave_fsm
   import twi_regbank_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h08
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic       sda_f,
   input  logic [7:0] rd_data,
   output logic       sda_drive_low,
   output logic       wr_en,
   output logic [7:0] wr_addr,
   output logic [7:0] wr_data,
   output logic [7:0] rd_ptr
);
   slv_state_t state_q;
   logic [3:0] bcnt_q;
   logic [7:0] shreg_q;
   logic       rw_q, data_seen_q, mack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         bcnt_q        <= '0;
         shreg_q       <= '0;
         rw_q          <= 1'b0;
         data_seen_q   <= 1'b0;
         mack_q        <= 1'b0;
         sda_drive_low <= 1'b0;
         wr_en         <= 1'b0;
         wr_addr       <= '0;
         wr_data       <= '0;
         rd_ptr        <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            state_q       <= ST_ADDR;
            bcnt_q        <= '0;
            data_seen_q   <= 1'b0;
            sda_drive_low <= 1'b0;
         end else if (stop_det) begin
            state_q       <= ST_IDLE;
            sda_drive_low <= 1'b0;
         end else begin
            case (state_q)
               ST_ADDR, ST_PTR, ST_DATA: begin
                  if (scl_rise) begin
                     shreg_q <= {shreg_q[6:0], sda_f};
                     bcnt_q  <= bcnt_q + 4'd1;
                  end else if (scl_fall && bcnt_q == 4'd8) begin
                     bcnt_q <= '0;
                     if (state_q == ST_ADDR) begin
                        if (shreg_q[7:1] == DEV_ADDR) begin
                           sda_drive_low <= 1'b1;
                           rw_q          <= shreg_q[0];
                           state_q       <= ST_ADDR_ACK;
                        end else begin
                           state_q <= ST_DRAIN;
                        end
                     end else if (state_q == ST_PTR) begin
                        sda_drive_low <= 1'b1;
                        rd_ptr        <= shreg_q;
                        state_q       <= ST_PTR_ACK;
                     end else begin
                        sda_drive_low <= ~data_seen_q;
                        state_q       <= ST_DATA_ACK;
                        if (!data_seen_q) begin
                           wr_en       <= 1'b1;
                           wr_addr     <= rd_ptr;
                           wr_data     <= shreg_q;
                           data_seen_q <= 1'b1;
                        end
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     if (rw_q) begin
                        shreg_q       <= rd_data;
                        sda_drive_low <= ~rd_data[7];
                        bcnt_q        <= '0;
                        state_q       <= ST_TX;
                     end else begin
                        sda_drive_low <= 1'b0;
                        state_q       <= ST_PTR;
                     end
                  end
               end
               ST_PTR_ACK: begin
                  if (scl_fall) begin
                     sda_drive_low <= 1'b0;
                     state_q       <= ST_DATA;
                  end
               end
               ST_DATA_ACK: begin
                  if (scl_fall) begin
                     sda_drive_low <= 1'b0;
                     state_q       <= sda_drive_low ? ST_DATA : ST_DRAIN;
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bcnt_q <= bcnt_q + 4'd1;
                  end else if (scl_fall) begin
                     if (bcnt_q == 4'd8) begin
                        sda_drive_low <= 1'b0;
                        state_q       <= ST_TX_ACK;
                     end else begin
                        shreg_q       <= {shreg_q[6:0], 1'b0};
                        sda_drive_low <= ~shreg_q[6];
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_f;
                  end else if (scl_fall) begin
                     if (mack_q) begin
                        shreg_q       <= rd_data;
                        sda_drive_low <= ~rd_data[7];
                        bcnt_q        <= '0;
                        state_q       <= ST_TX;
                     end else begin
                        state_q <= ST_DRAIN;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/twi_reg_file.sv
`timescale 1ns/1ps
module twi_reg_file
   import twi_regbank_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [7:0]            wr_addr,
   input  logic [7:0]            wr_data,
   output logic [REG_COUNT*8-1:0] bank_o,
   output logic [CODE_W-1:0]     mod_code_o,
   output logic [CODE_W-1:0]     bias_code_o
);
   generate
      for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
         localparam logic [7:0] MASK = live_mask(g);
         if (MASK == 8'h00) begin : g_absent
            assign bank_o[g*8 +: 8] = 8'h00;
         end else begin : g_present
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                           q <= '0;
               else if (wr_en && wr_addr == 8'(g))  q <= wr_data & MASK;
            end
            assign bank_o[g*8 +: 8] = q;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mod_code_o  <= '0;
         bias_code_o <= '0;
      end else if (wr_en) begin
         if (wr_addr == 8'(MOD_HI_IDX))
            mod_code_o  <= {wr_data, bank_o[MOD_LO_IDX*8 +: LO_W]};
         if (wr_addr == 8'(BIAS_HI_IDX))
            bias_code_o <= {wr_data, bank_o[BIAS_LO_IDX*8 +: LO_W]};
      end
   end
endmodule

// File: rtl/twi_ctrl_regbank.sv
`timescale 1ns/1ps
module twi_ctrl_regbank
   import twi_regbank_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR    = 7'h08,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_i,
   input  logic                   sda_i,
   output logic                   sda_drive_low,
   output logic [REG_COUNT*8-1:0] bank_o,
   output logic [CODE_W-1:0]      mod_code_o,
   output logic [CODE_W-1:0]      bias_code_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 1) begin : g_bad_filt
         $error("FILT_LEN must be at least 1");
      end
      if (REG_COUNT <= BIAS_HI_IDX) begin : g_bad_map
         $error("register map too small for split codes");
      end
   endgenerate

   logic       scl_filt, sda_filt;
   logic       scl_rise, scl_fall, start_det, stop_det;
   logic       wr_en;
   logic [7:0] wr_addr, wr_data, rd_ptr, rd_data;

   twi_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_filt));
   twi_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_filt));

   twi_bus_events u_events (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_filt), .sda_f(sda_filt),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   twi_slave_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det),
      .sda_f(sda_filt), .rd_data(rd_data),
      .sda_drive_low(sda_drive_low),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_ptr(rd_ptr));

   twi_reg_file u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .bank_o(bank_o), .mod_code_o(mod_code_o), .bias_code_o(bias_code_o));

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < REG_COUNT; i++)
         if (rd_ptr == 8'(i)) rd_data = bank_o[i*8 +: 8];
   end
endmodule

// File: rtl/twi_regbank_chk.sv
`timescale 1ns/1ps
module twi_regbank_chk
   import twi_regbank_pkg::*;
(
   input logic                   clk,
   input logic                   rst_n,
   input logic                   scl_f,
   input logic                   stop_det,
   input logic                   sda_drive_low,
   input logic                   wr_en,
   input logic [7:0]             wr_addr,
   input logic [REG_COUNT*8-1:0] bank,
   input logic [CODE_W-1:0]      mod_code,
   input logic [CODE_W-1:0]      bias_code
);
   function automatic logic [REG_COUNT*8-1:0] all_live();
      logic [REG_COUNT*8-1:0] m;
      for (int i = 0; i < REG_COUNT; i++) m[i*8 +: 8] = live_mask(i);
      return m;
   endfunction
   localparam logic [REG_COUNT*8-1:0] LIVE = all_live();

   // R7: reserved bits never set
   a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bank & ~LIVE) == '0);

   // R3: the bank moves only after a write strobe
   a_r3_bank_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bank) |-> $past(wr_en));

   // R8: split codes move only on a high-register write
   a_r8_mod_atomic: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mod_code) |-> $past(wr_en && wr_addr == 8'(MOD_HI_IDX)));
   a_r8_bias_atomic: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bias_code) |-> $past(wr_en && wr_addr == 8'(BIAS_HI_IDX)));

   // R10: data drive changes only while the clock is low, released after STOP
   a_r10_drive_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_drive_low) |-> !scl_f);
   a_r10_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_drive_low);
endmodule

bind twi_ctrl_regbank twi_regbank_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_f(scl_filt), .stop_det(stop_det),
   .sda_drive_low(sda_drive_low), .wr_en(wr_en), .wr_addr(wr_addr),
   .bank(bank_o), .mod_code(mod_code_o), .bias_code(bias_code_o));

// File: tb/twi_ctrl_regbank_tb_top.sv
`timescale 1ns/1ps
module twi_ctrl_regbank_tb_top;
   localparam int Q = 10;
   localparam logic [6:0] DEV = 7'h08;

   logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
   logic sda_line, sda_drive_low;
   logic [79:0] bank;
   logic [9:0]  mod_code, bias_code;
   int vectors = 0, miscompares = 0;
   bit done = 0, glitch_en = 0;
   logic [7:0] mdl [0:9];
   logic [9:0] exp_mod = '0, exp_bias = '0;

   assign sda_line = m_sda & ~sda_drive_low;

   twi_ctrl_regbank dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_drive_low(sda_drive_low), .bank_o(bank),
      .mod_code_o(mod_code), .bias_code_o(bias_code));

   always #2.5 clk = ~clk;

   function automatic logic [7:0] wmask(input int a);
      case (a)
         0, 3, 5, 6, 7: return 8'hFF;
         1, 8:          return 8'h0F;
         2, 4:          return 8'h03;
         9:             return 8'h01;
         default:       return 8'h00;
      endcase
   endfunction

   function automatic logic [79:0] exp_bank();
      logic [79:0] v;
      for (int i = 0; i < 10; i++) v[i*8 +: 8] = mdl[i];
      return v;
   endfunction

   function automatic logic [7:0] exp_read(input int a);
      return (a < 10) ? mdl[a] : 8'h00;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_write(input int a, input logic [7:0] d);
      if (a < 10) begin
         mdl[a] = d & wmask(a);
         if (a == 3) exp_mod  = {d, mdl[2][1:0]};
         if (a == 5) exp_bias = {d, mdl[4][1:0]};
      end
   endtask

   task automatic check_all(input string req);
      check(req, bank, exp_bank());
      check(req, {70'd0, mod_code}, {70'd0, exp_mod});
      check(req, {70'd0, bias_code}, {70'd0, exp_bias});
   endtask

   task automatic bus_start;
      m_sda = 1'b1; tick(Q);
      scl = 1'b1;   tick(Q);
      m_sda = 1'b0; tick(Q);
      scl = 1'b0;   tick(Q);
   endtask

   task automatic bus_stop;
      m_sda = 1'b0; tick(Q);
      scl = 1'b1;   tick(Q);
      m_sda = 1'b1; tick(2*Q);
   endtask

   task automatic put_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i];
         if (glitch_en) begin
            tick(3); scl = 1'b1; tick(1); scl = 1'b0; tick(Q-4);
         end else tick(Q);
         scl = 1'b1; tick(2*Q);
         scl = 1'b0; tick(Q);
      end
      m_sda = 1'b1; tick(Q);
      scl = 1'b1;   tick(Q);
      ack = ~sda_line;
      tick(Q);
      scl = 1'b0;   tick(Q);
   endtask

   task automatic get_byte(output logic [7:0] b, input logic mack);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q);
         scl = 1'b1; tick(Q);
         b[i] = sda_line;
         tick(Q);
         scl = 1'b0; tick(Q);
      end
      m_sda = ~mack; tick(Q);
      scl = 1'b1;    tick(2*Q);
      scl = 1'b0;    tick(Q);
      m_sda = 1'b1;
   endtask

   task automatic wr_reg(input int a, input logic [7:0] d, input string req);
      logic ka, kp, kd;
      bus_start;
      put_byte({DEV, 1'b0}, ka);
      put_byte(8'(a), kp);
      put_byte(d, kd);
      bus_stop;
      model_write(a, d);
      check(req, {77'd0, ka, kp, kd}, 80'd7);
   endtask

   task automatic set_ptr(input int a);
      logic ka, kp;
      bus_start;
      put_byte({DEV, 1'b0}, ka);
      put_byte(8'(a), kp);
      bus_stop;
      check("R4 pointer acks", {78'd0, ka, kp}, 80'd3);
   endtask

   task automatic rd_cur(input int a, input string req);
      logic ka;
      logic [7:0] b;
      bus_start;
      put_byte({DEV, 1'b1}, ka);
      get_byte(b, 1'b0);
      bus_stop;
      check(req, {71'd0, ka, b}, {71'd0, 1'b1, exp_read(a)});
   endtask

   initial begin
      logic ka, kp, kd, k2;
      logic [7:0] b;
      for (int i = 0; i < 10; i++) mdl[i] = 8'h00;
      void'($urandom(32'd20240611));
      tick(10);
      // R1: reset state
      check("R1 bank", bank, 80'd0);
      check("R1 codes", {60'd0, mod_code, bias_code}, 80'd0);
      check("R1 sda released", {79'd0, sda_drive_low}, 80'd0);
      rst_n = 1'b1; tick(10);

      // R3: plain write and read-back
      wr_reg(0, 8'hA5, "R3 write acks");
      check_all("R3 write reg0");
      set_ptr(0); rd_cur(0, "R4 read reg0");

      // R7: reserved bits
      wr_reg(1, 8'hFF, "R7 acks"); wr_reg(8, 8'hFF, "R7 acks"); wr_reg(9, 8'hFF, "R7 acks");
      check_all("R7 masked writes");
      set_ptr(1); rd_cur(1, "R4 R7 reserved reads zero");
      set_ptr(9); rd_cur(9, "R4 R7 reserved reads zero");

      // R8: split codes update only with the high byte
      wr_reg(2, 8'hFF, "R8 acks");
      check("R8 mod held after low write", {70'd0, mod_code}, 80'd0);
      check_all("R8 low staged");
      wr_reg(3, 8'h81, "R8 acks");
      check("R8 mod committed", {70'd0, mod_code}, 80'h207);
      wr_reg(4, 8'h02, "R8 acks");
      check("R8 bias held", {70'd0, bias_code}, 80'd0);
      wr_reg(5, 8'h3C, "R8 acks");
      check("R8 bias committed", {70'd0, bias_code}, {70'd0, 8'h3C, 2'b10});
      wr_reg(2, 8'h01, "R8 acks");
      check("R8 mod unchanged by new low", {70'd0, mod_code}, 80'h207);
      check_all("R8 state");

      // R2: foreign address
      bus_start;
      put_byte({7'h09, 1'b0}, ka); put_byte(8'h06, kp); put_byte(8'h77, kd);
      bus_stop;
      check("R2 foreign address nack", {77'd0, ka, kp, kd}, 80'd0);
      check_all("R2 bank untouched");

      // R5: second data byte
      bus_start;
      put_byte({DEV, 1'b0}, ka); put_byte(8'h06, kp); put_byte(8'h5A, kd); put_byte(8'hC3, k2);
      bus_stop;
      model_write(6, 8'h5A);
      check("R5 first acked, second refused", {76'd0, ka, kp, kd, k2}, 80'hE);
      check_all("R5 only first byte stored");

      // R6: pointer past the map
      wr_reg(11, 8'h55, "R6 acks beyond map");
      check_all("R6 bank unchanged");
      rd_cur(11, "R6 read beyond map");

      // R9: repeated start aborts a write and restarts decoding
      bus_start;
      put_byte({DEV, 1'b0}, ka); put_byte(8'h06, kp);
      bus_start;
      put_byte({DEV, 1'b0}, ka); put_byte(8'h07, kp); put_byte(8'h3C, kd);
      bus_stop;
      model_write(7, 8'h3C);
      check("R9 acks after restart", {77'd0, ka, kp, kd}, 80'd7);
      check_all("R9 restart write");
      bus_start;
      put_byte({DEV, 1'b0}, ka); put_byte(8'h05, kp);
      bus_start;
      put_byte({DEV, 1'b1}, ka); get_byte(b, 1'b0);
      bus_stop;
      check("R9 R4 combined read", {72'd0, b}, {72'd0, mdl[5]});

      // R11: one-cycle clock glitches are ignored
      glitch_en = 1;
      wr_reg(6, 8'h96, "R11 acks with glitches");
      glitch_en = 0;
      check_all("R11 write with glitches");

      // random mix
      for (int n = 0; n < 24; n++) begin
         int a;
         logic [7:0] d;
         a = int'($urandom_range(0, 11));
         d = 8'($urandom);
         wr_reg(a, d, "R3 random write acks");
         check_all("R3 R7 R8 random write");
         if ($urandom_range(0, 1) == 1) begin
            int r;
            r = int'($urandom_range(0, 11));
            set_ptr(r);
            rd_cur(r, "R4 random read");
         end
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule